// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked request port and an external asynchronous static RAM with a 17-bit word address and a 16-bit data path split into two byte lanes. Each request carries an address, a write flag, a two-bit lane mask and write data. A read result comes back on a one-cycle valid strobe. Results return in the order the reads were accepted. The memory side has active-low chip select, write strobe, output enable and one active-low enable per lane. It also has a split data path: an output bus, its drive enable, and an input bus. The pad ring joins these into the bidirectional pins.

Every memory timing limit is given in nanoseconds. Each one becomes a whole number of cycles of `CLK_PERIOD_NS`, rounded up. The control is a five-state machine:

- `ST_IDLE` accepts requests.
- A write goes `ST_IDLE -> ST_WSETUP -> ST_WPULSE -> ST_WHOLD -> ST_IDLE`.
  - `ST_WSETUP` presents the address and lanes, and waits out any bus turnaround.
  - `ST_WPULSE` holds the write strobe low.
  - `ST_WHOLD` keeps select and lanes asserted after the strobe rises, and stretches the access to the minimum cycle time.
- A read goes `ST_IDLE -> ST_RACCESS -> ST_IDLE`. `ST_RACCESS` holds select and output enable low for the access time, then captures the data.
- A request whose lane mask is zero stays on the `ST_IDLE -> ST_IDLE` arc.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11, and `mem_dq_oe` and `rsp_valid` are 0.
- R2: A write holds `mem_ce_n` low and `mem_be_n` equal to the inverted mask (bit 0 = data bits 7:0, bit 1 = data bits 15:8). It drives `mem_we_n` low for at least 35 ns, with the address stable at least 35 ns before the strobe rises. The write ends only by `mem_we_n` rising, while `mem_ce_n` stays low and `mem_be_n` is unchanged.
- R3: `mem_dq_oe` is 1 only while `mem_we_n` is 0 and `mem_oe_n` is 1. It rises one cycle after `mem_we_n` falls, stays on at least 25 ns before `mem_we_n` rises, and is 0 from the cycle in which `mem_we_n` rises.
- R4: A read holds `mem_ce_n` and `mem_oe_n` low, `mem_we_n` high and `mem_be_n` equal to the inverted mask. It samples the input bus no earlier than 45 ns after the access starts. It then pulses `rsp_valid` for one cycle with the data, and any lane whose mask bit is 0 reads as zero.
- R5: A write changes only the lanes whose mask bit is 1; the other lane keeps its earlier value on readback.
- R6: The controller never turns on `mem_dq_oe` within 18 ns of `mem_oe_n` rising.
- R7: Every access holds `mem_ce_n` low for at least 45 ns.
- R8: A request with mask 2'b00 leaves `mem_ce_n` high and `req_ready` at 1 the next cycle. As a write it changes nothing. As a read it returns `rsp_valid` with zero data the next cycle.
- R9: `req_ready` is 1 only in `ST_IDLE`, and a request is taken at a clock edge where `req_valid` and `req_ready` are both 1. Read results come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 17 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_be_n | output | 2 | Memory lane enables, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the memory |

## Verification
The cycle-level rules hold on every cycle and are checked each cycle:

- The drive window sits inside the write strobe with output enable high.
- The strobes never overlap illegally.
- The write ends only by the strobe edge, with select and lanes steady.
- The strobe width and the turnaround gap are measured in cycles.
- `req_ready` implies an idle bus.

Only the bench scenarios can show the rest. Lane masking must leave the other byte intact on readback. Read data must be sampled after the access time, which the bench's memory model enforces by returning junk until then. Zero-mask requests must not touch the memory. Results must come back in order, and the timing must hold in nanoseconds at the actual clock period.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WHOLD,
        ST_RACCESS
    } ctrl_state_t;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_wait_cnt.sv
`timescale 1ns/1ps
module sram_wait_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_bus_guard.sv
`timescale 1ns/1ps
module sram_bus_guard #(
    parameter int W        = 8,
    parameter int TURN_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    logic [W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (start) begin
            gap_q <= W'(TURN_CYC);
        end else if (gap_q != '0) begin
            gap_q <= gap_q - 1'b1;
        end
    end

    assign busy = (gap_q != '0);
endmodule

// File: rtl/sram_lane_mask.sv
`timescale 1ns/1ps
module sram_lane_mask #(
    parameter int LANES = 2
) (
    input  logic [8*LANES-1:0] data_in,
    input  logic [LANES-1:0]   lane_en,
    output logic [8*LANES-1:0] data_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign data_out[8*g +: 8] = lane_en[g] ? data_in[8*g +: 8] : 8'h00;
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 16,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WC_NS       = 45,
    parameter int T_PWE_NS      = 35,
    parameter int T_SD_NS       = 25,
    parameter int T_AA_NS       = 45,
    parameter int T_DOE_NS      = 22,
    parameter int T_RC_NS       = 45,
    parameter int T_HZ_NS       = 18,
    parameter int CNT_W         = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic                  req_write,
    input  logic [DATA_W/8-1:0]   req_mask,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);
    localparam int LANES    = DATA_W / 8;
    localparam int PWE_CYC  = imax(cdiv(T_PWE_NS, CLK_PERIOD_NS),
                                   1 + cdiv(T_SD_NS, CLK_PERIOD_NS));
    localparam int WC_CYC   = cdiv(T_WC_NS, CLK_PERIOD_NS);
    localparam int HOLD_RAW = WC_CYC - 1 - PWE_CYC;
    localparam int HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
    localparam int RD_CYC   = imax(cdiv(T_AA_NS, CLK_PERIOD_NS),
                                   imax(cdiv(T_DOE_NS, CLK_PERIOD_NS),
                                        cdiv(T_RC_NS, CLK_PERIOD_NS)));
    localparam int TURN_CYC = cdiv(T_HZ_NS, CLK_PERIOD_NS);

    ctrl_state_t state_q, state_d;

    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_done;
    logic              turn_start;
    logic              turn_busy;
    logic              accept;
    logic              null_req;
    logic              rd_finish;
    logic              null_read;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  mask_q;
    logic              drive_q;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_masked;

    sram_wait_cnt #(.W(CNT_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .done     (cnt_done)
    );

    sram_bus_guard #(.W(CNT_W), .TURN_CYC(TURN_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .start (turn_start),
        .busy  (turn_busy)
    );

    sram_lane_mask #(.LANES(LANES)) u_mask (
        .data_in  (mem_dq_in),
        .lane_en  (mask_q),
        .data_out (rd_masked)
    );

    // Next-state and counter control
    always_comb begin
        state_d    = state_q;
        cnt_load   = 1'b0;
        cnt_val    = '0;
        accept     = 1'b0;
        null_req   = 1'b0;
        turn_start = 1'b0;
        rd_finish  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_mask == '0) begin
                        null_req = 1'b1;
                    end else if (req_write) begin
                        state_d = ST_WSETUP;
                    end else begin
                        state_d  = ST_RACCESS;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                if (!turn_busy) begin
                    state_d  = ST_WPULSE;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(PWE_CYC - 1);
                end
            end
            ST_WPULSE: begin
                if (cnt_done) begin
                    state_d  = ST_WHOLD;
                    cnt_load = 1'b1;
                    cnt_val  = CNT_W'(HOLD_CYC - 1);
                end
            end
            ST_WHOLD: begin
                if (cnt_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_RACCESS: begin
                if (cnt_done) begin
                    state_d    = ST_IDLE;
                    turn_start = 1'b1;
                    rd_finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign null_read = accept && null_req && !req_write;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request capture, drive enable and response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            mask_q      <= '0;
            drive_q     <= 1'b0;
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                mask_q  <= req_mask;
            end
            drive_q     <= (state_q == ST_WPULSE) && (state_d == ST_WPULSE);
            rsp_valid_q <= null_read || rd_finish;
            if (null_read) begin
                rdata_q <= '0;
            end else if (rd_finish) begin
                rdata_q <= rd_masked;
            end
        end
    end

    // Memory strobes decoded from state
    always_comb begin
        mem_ce_n = 1'b1;
        mem_we_n = 1'b1;
        mem_oe_n = 1'b1;
        mem_be_n = '1;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_WSETUP: begin
                mem_ce_n = 1'b0;
                mem_be_n = ~mask_q;
            end
            ST_WPULSE: begin
                mem_ce_n = 1'b0;
                mem_we_n = 1'b0;
                mem_be_n = ~mask_q;
            end
            ST_WHOLD: begin
                mem_ce_n = 1'b0;
                mem_be_n = ~mask_q;
            end
            ST_RACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
                mem_be_n = ~mask_q;
            end
            default: begin
            end
        endcase
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign mem_dq_oe  = drive_q;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_rdata  = rdata_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk
    import sram_lane_pkg::*;
#(
    parameter int LANES         = 2,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_PWE_NS      = 35,
    parameter int T_HZ_NS       = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             mem_ce_n,
    input logic             mem_we_n,
    input logic             mem_oe_n,
    input logic [LANES-1:0] mem_be_n,
    input logic             mem_dq_oe
);
    localparam int PWE_MIN  = cdiv(T_PWE_NS, CLK_PERIOD_NS);
    localparam int TURN_MIN = cdiv(T_HZ_NS, CLK_PERIOD_NS);

    logic [7:0] we_low_cnt;
    logic [7:0] oe_hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_cnt <= '0;
            oe_hi_cnt  <= 8'hFF;
        end else begin
            if (!mem_we_n) begin
                if (we_low_cnt != 8'hFF) we_low_cnt <= we_low_cnt + 1'b1;
            end else begin
                we_low_cnt <= '0;
            end
            if (!mem_oe_n) begin
                oe_hi_cnt <= '0;
            end else if (oe_hi_cnt != 8'hFF) begin
                oe_hi_cnt <= oe_hi_cnt + 1'b1;
            end
        end
    end

    assert_drive_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    assert_write_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && (mem_be_n != '1) && mem_oe_n));

    assert_single_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (!mem_ce_n && $stable(mem_be_n) && !mem_dq_oe));

    assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (int'(we_low_cnt) >= PWE_MIN));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (int'(oe_hi_cnt) >= TURN_MIN));

    assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_we_n && (mem_be_n != '1)));

    assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .LANES         (LANES),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_PWE_NS      (T_PWE_NS),
    .T_HZ_NS       (T_HZ_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_be_n  (mem_be_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [16:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mask = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [16:0] mem_addr;
    logic        mem_ce_n, mem_we_n, mem_oe_n;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in = 16'hA5A5;

    int n_vec  = 0;
    int n_miss = 0;
    bit finished = 1'b0;

    logic [15:0] model_mem [int];
    logic [15:0] shadow    [int];
    logic [15:0] exp_q [$];

    realtime t_addr = -1000.0, t_we_fall = -1000.0, t_dq_rise = -1000.0;
    realtime t_oe_fall = -1000.0, t_oe_rise = -1000.0, t_ce_fall = -1000.0;

    always #5 clk = ~clk;

    sram_lane_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_mask(req_mask), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_miss++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_bits(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic logic [15:0] rd_word(input logic [15:0] arr [int], input int a);
        return arr.exists(a) ? arr[a] : 16'h0000;
    endfunction

    // Memory model: timing edges
    always @(mem_addr)         t_addr    = $realtime;
    always @(negedge mem_we_n) t_we_fall = $realtime;
    always @(posedge mem_oe_n) t_oe_rise = $realtime;
    always @(negedge mem_oe_n) t_oe_fall = $realtime;
    always @(negedge mem_ce_n) t_ce_fall = $realtime;

    always @(posedge mem_dq_oe) begin
        chk(($realtime - t_oe_rise) >= 18.0 && mem_oe_n, "R6 turnaround gap ns",
            32'($rtoi($realtime - t_oe_rise)), 32'd18);
        t_dq_rise = $realtime;
    end

    always @(posedge mem_ce_n) begin
        if ($realtime > 1.0)
            chk(($realtime - t_ce_fall) >= 45.0, "R7 select low ns",
                32'($rtoi($realtime - t_ce_fall)), 32'd45);
    end

    // Memory model: write at the rising write strobe
    always @(posedge mem_we_n) begin
        if ($realtime > 1.0 && !mem_ce_n) begin
            logic [15:0] w;
            chk(($realtime - t_we_fall) >= 35.0, "R2 strobe width ns",
                32'($rtoi($realtime - t_we_fall)), 32'd35);
            chk(($realtime - t_addr) >= 35.0, "R2 address setup ns",
                32'($rtoi($realtime - t_addr)), 32'd35);
            chk(t_dq_rise > t_we_fall && ($realtime - t_dq_rise) >= 25.0,
                "R3 data setup ns", 32'($rtoi($realtime - t_dq_rise)), 32'd25);
            w = rd_word(model_mem, int'(mem_addr));
            for (int i = 0; i < 2; i++)
                if (!mem_be_n[i]) w[8*i +: 8] = mem_dq_out[8*i +: 8];
            model_mem[int'(mem_addr)] = w;
        end
    end

    // Memory model: read data valid only after access times
    initial forever begin
        logic [15:0] w;
        logic ok;
        #1;
        ok = !mem_ce_n && !mem_oe_n && mem_we_n &&
             (($realtime - t_addr) >= 45.0) && (($realtime - t_oe_fall) >= 22.0) &&
             (($realtime - t_ce_fall) >= 45.0);
        w = rd_word(model_mem, int'(mem_addr));
        for (int i = 0; i < 2; i++)
            mem_dq_in[8*i +: 8] = (ok && !mem_be_n[i]) ? w[8*i +: 8] : 8'hA5;
    end

    // Monitor: scoreboard and per-cycle port rules
    initial begin
        logic       prev_we;
        logic [1:0] prev_be;
        prev_we = 1'b1;
        prev_be = 2'b11;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (rsp_valid) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected response", 32'(rsp_rdata), 32'h0);
                    end else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        chk(rsp_rdata == e, "R4 read data", 32'(rsp_rdata), 32'(e));
                    end
                end
                if (mem_dq_oe)
                    chk(!mem_we_n && mem_oe_n, "R3 drive window",
                        {30'd0, mem_we_n, mem_oe_n}, 32'h1);
                if (!prev_we && mem_we_n)
                    chk(!mem_ce_n && mem_be_n == prev_be && !mem_dq_oe,
                        "R2 single terminating edge",
                        {28'd0, mem_ce_n, mem_be_n, mem_dq_oe}, {28'd0, 1'b0, prev_be, 1'b0});
                if (!mem_oe_n)
                    chk(!mem_ce_n && mem_we_n, "R4 read strobes",
                        {30'd0, mem_ce_n, mem_we_n}, 32'h1);
                prev_we = mem_we_n;
                prev_be = mem_be_n;
            end
        end
    end

    // Driver: issue one request and record what it should produce
    task automatic do_req(input logic [16:0] a, input logic wr,
                          input logic [1:0] m, input logic [15:0] d);
        req_addr  = a;
        req_write = wr;
        req_mask  = m;
        req_wdata = d;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        if (wr) begin
            logic [15:0] w;
            w = rd_word(shadow, int'(a));
            w = (w & ~lane_bits(m)) | (d & lane_bits(m));
            shadow[int'(a)] = w;
        end else begin
            exp_q.push_back(rd_word(shadow, int'(a)) & lane_bits(m));
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (m != 2'b00)
            chk(req_ready == 1'b0, "R9 busy after accept", 32'(req_ready), 32'h0);
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [16:0] a_list [16];
        logic [15:0] d_list [16];

        repeat (3) @(negedge clk);
        chk(req_ready && mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 &&
            !mem_dq_oe && !rsp_valid, "R1 reset state",
            {25'd0, req_ready, mem_ce_n, mem_we_n, mem_oe_n, mem_be_n, mem_dq_oe},
            {25'd0, 7'b1111110});
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && mem_ce_n, "R1 idle after reset", {30'd0, req_ready, mem_ce_n}, 32'h3);

        do_req(17'h00010, 1'b1, 2'b11, 16'h1234);
        do_req(17'h00010, 1'b0, 2'b11, 16'h0);
        // R5 low lane only, then high lane only
        do_req(17'h00010, 1'b1, 2'b01, 16'hABCD);
        do_req(17'h00010, 1'b0, 2'b11, 16'h0);
        do_req(17'h00010, 1'b1, 2'b10, 16'h99EE);
        do_req(17'h00010, 1'b0, 2'b11, 16'h0);
        // R4 single-lane reads return zero on the other lane
        do_req(17'h00010, 1'b0, 2'b01, 16'h0);
        do_req(17'h00010, 1'b0, 2'b10, 16'h0);
        // R6 read immediately followed by write, boundary addresses
        do_req(17'h1FFFF, 1'b0, 2'b11, 16'h0);
        do_req(17'h1FFFF, 1'b1, 2'b11, 16'hFEDC);
        do_req(17'h00000, 1'b1, 2'b11, 16'h0F0F);
        do_req(17'h1FFFF, 1'b0, 2'b11, 16'h0);
        do_req(17'h00000, 1'b0, 2'b11, 16'h0);

        // R8 zero-mask write: no select, still ready, memory unchanged
        do_req(17'h00010, 1'b1, 2'b00, 16'hFFFF);
        chk(req_ready && mem_ce_n, "R8 zero-mask write idle", {30'd0, req_ready, mem_ce_n}, 32'h3);
        do_req(17'h00010, 1'b0, 2'b00, 16'h0);
        chk(req_ready && mem_ce_n, "R8 zero-mask read idle", {30'd0, req_ready, mem_ce_n}, 32'h3);
        do_req(17'h00010, 1'b0, 2'b11, 16'h0);

        // R2 R4 R9 pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 16; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a_list[i] = {lfsr[0], lfsr};
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            d_list[i] = lfsr;
        end
        for (int i = 0; i < 16; i++)
            do_req(a_list[i], 1'b1, 2'(i % 3 + 1), d_list[i]);
        for (int i = 0; i < 16; i++)
            do_req(a_list[15 - i], 1'b0, 2'(i % 4), 16'h0);

        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R9 all responses returned", 32'(exp_q.size()), 32'h0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_miss++;
            $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end
endmodule